// File: doc/BRIEF.md
# Power-Mode and Reset Sequencer

This block turns a two-bit power-mode field from the configuration registers, plus an asynchronous external power-down pin, into the per-cycle control levels for a converter's digital data path. The outputs are a clock enable for the data-path clocks, a synchronous reset for the data-path logic, an enable for the output drivers, and a keep-alive level for the configuration port. The configuration port is never reset or disabled by any mode; only power-on reset (`rst_ni`) clears it.

A configuration bit chooses what the external pin requests: standby or full power-down. When the pin request and the register mode differ, the more restrictive state wins, ranked power-down, then standby, then normal. The digital-reset mode is applied on top of whichever state results. The pin is synchronized by two flops before use.

Leaving power-down into a clock-running state goes through a wake phase. In this phase the clocks run while the data-path reset stays asserted for `HOLD_CYC` cycles (2 by default). Only after that are the outputs enabled. Power-on reset leaves the block in power-down, so the first cycles after reset release also pass through the wake phase.

Top module: `pwr_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are `dp_clk_en_o`=0, `dp_rst_o`=1, `out_en_o`=0 and `cfg_alive_o`=0, asynchronously.
- R2: `cfg_alive_o` is 1 from the first clock edge after reset release and stays 1 whatever the mode or pin; only `rst_ni` clears it.
- R3: Mode code 2'b00 (normal), with the pin inactive and no wake phase pending, gives clock enable 1, data-path reset 0 and output enable 1.
- R4: Mode code 2'b01 (power-down) gives clock enable 0, data-path reset 1 and output enable 0.
- R5: Mode code 2'b10 (standby) gives clock enable 0 and output enable 0, with data-path reset 0 unless digital reset or power-down also applies.
- R6: Mode code 2'b11 (digital reset) forces data-path reset 1 and output enable 0. The clock enable follows the state chosen by the pin, which is 1 when the pin is inactive.
- R7: `pwr_pin_i` is active high. With `pin_standby_sel_i`=1 it requests standby; with `pin_standby_sel_i`=0 it requests power-down.
- R8: When the pin request and the register mode differ, the more restrictive state applies: power-down over standby over normal.
- R9: A change of `pwr_mode_i` reaches the outputs at the first clock edge after it. A change of `pwr_pin_i` reaches them at the third edge (two synchronizer flops, then the state register).
- R10: Leaving power-down into a clock-running state first gives `HOLD_CYC` (default 2) cycles of clock enable 1, data-path reset 1 and output enable 0, and then the target state. Leaving power-down into standby goes straight to standby. A return to power-down during the wake phase takes effect at once.
- R11: `out_en_o`=1 only while `dp_clk_en_o`=1 and `dp_rst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pwr_mode_i | input | 2 | Register power mode: 00 normal, 01 power-down, 10 standby, 11 digital reset |
| pin_standby_sel_i | input | 1 | 1: external pin requests standby; 0: it requests power-down |
| pwr_pin_i | input | 1 | Asynchronous external power-down pin, active high |
| dp_clk_en_o | output | 1 | Data-path clock enable |
| dp_rst_o | output | 1 | Data-path synchronous reset |
| out_en_o | output | 1 | Output driver enable |
| cfg_alive_o | output | 1 | Configuration port keep-alive |

## Verification
Two functions can fall in the same cycle: the wake-phase hold after power-down and the digital-reset overlay. Both want clocks running and reset asserted, so a design that lets one clear the other shows up only when they coincide. The bench provokes this by switching the mode straight from power-down to digital reset. It then checks that reset and output disable hold through the wake cycles and after them, and that a later return to normal enables the outputs at once. The same collision is provoked between the pin and the register mode: all sixteen mode, select and pin combinations are swept and compared with a priority computed arithmetically in the bench.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // ranked by restriction: a larger value wins
  typedef enum logic [1:0] {
    LVL_RUN  = 2'd0,
    LVL_STBY = 2'd1,
    LVL_PDN  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_PDN  = 2'd2,
    ST_WAKE = 2'd3
  } st_e;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_PDN  = 2'b01;
  localparam logic [1:0] MODE_STBY = 2'b10;
  localparam logic [1:0] MODE_DRST = 2'b11;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[0] <= 1'b0;
          else         sr_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb
  import pwr_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       pin_sel_stby_i,
  input  logic       pin_req_i,
  output lvl_e       lvl_o,
  output logic       dig_rst_o
);
  lvl_e reg_lvl, pin_lvl;

  always_comb begin
    unique case (mode_i)
      MODE_PDN:  reg_lvl = LVL_PDN;
      MODE_STBY: reg_lvl = LVL_STBY;
      default:   reg_lvl = LVL_RUN;
    endcase
  end

  always_comb begin
    if (!pin_req_i)          pin_lvl = LVL_RUN;
    else if (pin_sel_stby_i) pin_lvl = LVL_STBY;
    else                     pin_lvl = LVL_PDN;
  end

  assign lvl_o     = (pin_lvl > reg_lvl) ? pin_lvl : reg_lvl;
  assign dig_rst_o = (mode_i == MODE_DRST);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e lvl_i,
  input  logic dig_rst_i,
  output logic dp_clk_en_o,
  output logic dp_rst_o,
  output logic out_en_o,
  output logic cfg_alive_o
);
  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYC - 1);

  st_e         st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        dig_q;
  logic        alive_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (lvl_i)
      LVL_PDN:  st_d = ST_PDN;
      LVL_STBY: st_d = ST_STBY;
      default: begin
        if (st_q == ST_PDN) begin
          st_d  = ST_WAKE;
          cnt_d = CNT_LOAD;
        end else if (st_q == ST_WAKE) begin
          if (cnt_q == '0) st_d = ST_RUN;
          else             cnt_d = cnt_q - 1'b1;
        end else begin
          st_d = ST_RUN;
        end
      end
    endcase
  end

  // power-on leaves the data path in power-down, so release goes through wake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PDN;
      cnt_q   <= '0;
      dig_q   <= 1'b0;
      alive_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      dig_q   <= dig_rst_i;
      alive_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RUN: begin
        dp_clk_en_o = 1'b1;
        dp_rst_o    = dig_q;
        out_en_o    = !dig_q;
      end
      ST_STBY: begin
        dp_clk_en_o = 1'b0;
        dp_rst_o    = dig_q;
        out_en_o    = 1'b0;
      end
      ST_WAKE: begin
        dp_clk_en_o = 1'b1;
        dp_rst_o    = 1'b1;
        out_en_o    = 1'b0;
      end
      default: begin
        dp_clk_en_o = 1'b0;
        dp_rst_o    = 1'b1;
        out_en_o    = 1'b0;
      end
    endcase
  end

  assign cfg_alive_o = alive_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwr_mode_i,
  input  logic       pin_standby_sel_i,
  input  logic       pwr_pin_i,
  output logic       dp_clk_en_o,
  output logic       dp_rst_o,
  output logic       out_en_o,
  output logic       cfg_alive_o
);
  logic pin_req;
  lvl_e lvl;
  logic dig_rst;

  pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_pin_i),
    .q_o   (pin_req)
  );

  pwr_seq_arb u_arb (
    .mode_i        (pwr_mode_i),
    .pin_sel_stby_i(pin_standby_sel_i),
    .pin_req_i     (pin_req),
    .lvl_o         (lvl),
    .dig_rst_o     (dig_rst)
  );

  pwr_seq_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .dig_rst_i  (dig_rst),
    .dp_clk_en_o(dp_clk_en_o),
    .dp_rst_o   (dp_rst_o),
    .out_en_o   (out_en_o),
    .cfg_alive_o(cfg_alive_o)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pwr_mode_i,
  input logic       dp_clk_en_o,
  input logic       dp_rst_o,
  input logic       out_en_o,
  input logic       cfg_alive_o
);
  AST_CFG_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cfg_alive_o); // R2

  AST_PDN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_mode_i) == 2'b01 |-> (!dp_clk_en_o && dp_rst_o && !out_en_o)); // R4

  AST_STBY_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_mode_i) == 2'b10 |-> (!dp_clk_en_o && !out_en_o)); // R5

  AST_DRST_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_mode_i) == 2'b11 |-> (dp_rst_o && !out_en_o)); // R6

  AST_WAKE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!dp_clk_en_o && dp_rst_o) && dp_clk_en_o) |-> (dp_rst_o && !out_en_o)); // R10

  AST_WAKE_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!dp_clk_en_o && dp_rst_o) && dp_clk_en_o)
      |=> ((dp_rst_o && !out_en_o) || !dp_clk_en_o)); // R10

  AST_OUT_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> (dp_clk_en_o && !dp_rst_o)); // R11
endmodule

bind pwr_seq pwr_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_mode_i (pwr_mode_i),
  .dp_clk_en_o(dp_clk_en_o),
  .dp_rst_o   (dp_rst_o),
  .out_en_o   (out_en_o),
  .cfg_alive_o(cfg_alive_o)
);

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pwr_mode_i = 2'b00;
  logic       pin_standby_sel_i = 1'b0;
  logic       pwr_pin_i = 1'b0;
  logic       dp_clk_en_o, dp_rst_o, out_en_o, cfg_alive_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  pwr_seq dut_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .pwr_mode_i       (pwr_mode_i),
    .pin_standby_sel_i(pin_standby_sel_i),
    .pwr_pin_i        (pwr_pin_i),
    .dp_clk_en_o      (dp_clk_en_o),
    .dp_rst_o         (dp_rst_o),
    .out_en_o         (out_en_o),
    .cfg_alive_o      (cfg_alive_o)
  );

  // {clk_en, dp_rst, out_en, alive}
  localparam logic [3:0] V_RUN  = 4'b1011;
  localparam logic [3:0] V_PDN  = 4'b0101;
  localparam logic [3:0] V_STBY = 4'b0001;
  localparam logic [3:0] V_WAKE = 4'b1101;
  localparam logic [3:0] V_POR  = 4'b0100;

  function automatic logic [3:0] exp_steady(int m, int s, int p);
    int rl, pl, lv;
    bit dg;
    rl = (m == 1) ? 2 : (m == 2) ? 1 : 0;
    pl = (p == 0) ? 0 : (s == 1) ? 1 : 2;
    lv = (rl > pl) ? rl : pl;
    dg = (m == 3);
    return {lv == 0, (lv == 2) || dg, (lv == 0) && !dg, 1'b1};
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {dp_clk_en_o, dp_rst_o, out_en_o, cfg_alive_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b (clk_en,dp_rst,out_en,alive) t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic settle_run();
    pwr_mode_i = 2'b00;
    pwr_pin_i  = 1'b0;
    step(10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk("R1 reset levels", V_POR);

    // release: passes through wake first
    rst_ni = 1'b1;
    step(1); chk("R10 post-reset wake 1", V_WAKE);
    step(1); chk("R10 post-reset wake 2", V_WAKE);
    step(1); chk("R3 R2 normal after wake", V_RUN);

    // exhaustive sweep of mode x select x pin from normal
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 2; p++) begin
          settle_run();
          pwr_mode_i        = 2'(m);
          pin_standby_sel_i = 1'(s);
          pwr_pin_i         = 1'(p);
          step(4);
          case ({p[0], 2'(m)})
            3'b000:  chk("R3 sweep", exp_steady(m, s, p));
            3'b001:  chk("R4 sweep", exp_steady(m, s, p));
            3'b010:  chk("R5 sweep", exp_steady(m, s, p));
            3'b011:  chk("R6 sweep", exp_steady(m, s, p));
            default: chk("R7 R8 sweep", exp_steady(m, s, p));
          endcase
        end
      end
    end

    // pin latency and wake after pin release
    settle_run();
    pin_standby_sel_i = 1'b0;
    pwr_pin_i = 1'b1;
    step(1); chk("R9 pin edge1", V_RUN);
    step(1); chk("R9 pin edge2", V_RUN);
    step(1); chk("R9 pin edge3", V_PDN);
    pwr_pin_i = 1'b0;
    step(2); chk("R9 pin release edge2", V_PDN);
    step(1); chk("R10 pin wake 1", V_WAKE);
    step(1); chk("R10 pin wake 2", V_WAKE);
    step(1); chk("R10 pin wake done", V_RUN);

    // mode latency and register-driven wake
    pwr_mode_i = 2'b01;
    step(1); chk("R9 R4 mode one edge", V_PDN);
    pwr_mode_i = 2'b00;
    step(1); chk("R10 mode wake 1", V_WAKE);
    step(1); chk("R10 mode wake 2", V_WAKE);
    step(1); chk("R10 R3 mode wake done", V_RUN);

    // power-down to standby skips the hold
    pwr_mode_i = 2'b01;
    step(2);
    pwr_mode_i = 2'b10;
    step(1); chk("R10 R5 pdn to stby", V_STBY);
    pwr_mode_i = 2'b00;
    step(1); chk("R10 stby to run direct", V_RUN);

    // wake interrupted by power-down
    pwr_mode_i = 2'b01;
    step(2);
    pwr_mode_i = 2'b00;
    step(1); chk("R10 wake start", V_WAKE);
    pwr_mode_i = 2'b01;
    step(1); chk("R10 R8 wake abort", V_PDN);

    // wake hold and digital reset together
    pwr_mode_i = 2'b11;
    step(1); chk("R10 R6 wake+drst 1", V_WAKE);
    step(1); chk("R10 R6 wake+drst 2", V_WAKE);
    step(1); chk("R6 drst after wake", V_WAKE);
    pwr_mode_i = 2'b00;
    step(1); chk("R6 R3 drst release", V_RUN);

    // pin standby with digital reset, then pin power-down over standby mode
    pin_standby_sel_i = 1'b1;
    pwr_pin_i = 1'b1;
    pwr_mode_i = 2'b11;
    step(4); chk("R6 R7 stby+drst", 4'b0101);
    pin_standby_sel_i = 1'b0;
    pwr_mode_i = 2'b10;
    step(1); chk("R8 pin pdn over stby", V_PDN);

    // asynchronous power-on reset mid-run
    settle_run();
    #1 rst_ni = 1'b0;
    #1 chk("R1 R2 async reset", V_POR);
    step(2);
    rst_ni = 1'b1;
    step(3); chk("R2 R3 after second reset", V_RUN);

    finish_run();
  end
endmodule